// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block gives an in-order processor loops that cost no branch instructions. A loop-start instruction hands the controller an iteration count, taken either from a register operand or from a short immediate, and a body length. The controller records the body start, the body end address and the remaining count as one entry on a small stack. Each executed instruction presents its PC. When that PC equals the end address of the top entry, the controller either overrides the next fetch address with the body start or retires the entry and lets execution fall through.

The controller also screens every executed instruction for illegal loop use. It flags a zero count, a body that ends beyond instruction memory, a start on a full stack, a loop start sitting on the active end address, and a branch or jump sitting on that address. When any of these fires, the stack is left untouched and no redirect is issued. All outputs are combinational from the current instruction, and state changes on the clock edge that retires it.

Top module: `hwloop_ctrl`

## Requirements
- R1: With `cnt_imm_sel_i`=1 the count is `cnt_imm_i` zero-extended, otherwise it is `cnt_reg_i`. A body started with count N is run N times. The all-ones 32-bit count is legal and raises no error.
- R2: A loop start with a count of zero raises `err_zero_cnt_o`.
- R3: The body runs from pc+1 to pc+1+`body_len_i`. If that end lies beyond word address IMEM_WORDS-1 (1023 by default), `err_bad_end_o` is raised. An end of exactly 1023 is accepted.
- R4: A loop start while STACK_DEPTH (8) loops are open raises `err_stack_full_o`.
- R5: A loop start whose own PC equals the top entry's end address raises `err_start_at_end_o`.
- R6: A branch or jump (`is_xfer_i`=1) whose PC equals the top entry's end address raises `err_xfer_at_end_o`, and no redirect is issued.
- R7: Errors detected together are all raised in the same cycle. Any error leaves the loop state unchanged and suppresses the redirect.
- R8: Only the top entry's end address triggers loop-back. An enclosing loop's end address, met inside an inner body, passes through with no redirect.
- R9: A one-instruction body with count 1 runs once and then retires with no redirect.
- R10: At the top end address with more than one iteration left, `redir_vld_o` is raised in the same cycle and `redir_pc_o` is the body start. With the stack empty, no redirect ever occurs.
- R11: A new loop may share its end address with the top entry. When the inner loop retires at that address, the enclosing loop is serviced by the same instruction.
- R12: After the last open loop retires, the stack is empty, even if it was full before. It can then accept STACK_DEPTH new loops.
- R13: Reaching a body's end address by a jump from outside loops back normally. A branch or jump inside a body but not at its end raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_vld_i | input | 1 | An instruction at `pc_i` executes this cycle |
| pc_i | input | PC_W | Word address of the executing instruction |
| is_xfer_i | input | 1 | The instruction is a branch or jump |
| loop_req_i | input | 1 | The instruction starts a loop |
| cnt_imm_sel_i | input | 1 | 1 selects the immediate count, 0 selects the register count |
| cnt_imm_i | input | IMM_W | Immediate iteration count |
| cnt_reg_i | input | CNT_W | Register iteration count |
| body_len_i | input | LEN_W | Body length minus one, in instructions |
| redir_vld_o | output | 1 | Override the next fetch address |
| redir_pc_o | output | PC_W | Next fetch address when overriding |
| err_zero_cnt_o | output | 1 | Zero iteration count |
| err_bad_end_o | output | 1 | Body end beyond instruction memory |
| err_stack_full_o | output | 1 | Loop stack overflow |
| err_start_at_end_o | output | 1 | Loop start on the active end address |
| err_xfer_at_end_o | output | 1 | Branch or jump on the active end address |

## Verification
The loop-back path is tried with several shapes:
- Single-level bodies with counts of 1, 2 and 3 show that the number of redirects matches the count and that the redirect target is the body start.
- A badly nested pair tells a top-only end match apart from a match against any open loop.
- A pair with a shared end address tells same-instruction servicing of the enclosing loop apart from a stuck entry.
- Filling the stack, draining it and filling it again separates a true return to empty from a stale depth.
- Error cases are driven both singly and in pairs, and each is followed by plain execution of the end address, which shows that the stored count did not move.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

   // Error flags raised by one executed instruction.
   typedef struct packed {
      logic zero_cnt;
      logic bad_end;
      logic stack_full;
      logic start_at_end;
      logic xfer_at_end;
   } loop_err_t;

   localparam int unsigned DEF_CNT_W = 32;

endpackage

// File: rtl/hwloop_stack.sv
module hwloop_stack #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned PC_W  = 10,
   parameter int unsigned CNT_W = 32,
   parameter int unsigned SPW   = $clog2(DEPTH + 1),
   parameter int unsigned IDXW  = $clog2(DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [PC_W-1:0]  push_start_i,
   input  logic [PC_W-1:0]  push_end_i,
   input  logic [CNT_W-1:0] push_cnt_i,
   input  logic [SPW-1:0]   pop_n_i,
   input  logic             dec_i,
   input  logic [IDXW-1:0]  dec_idx_i,
   output logic [SPW-1:0]   sp_o,
   output logic [PC_W-1:0]  start_o [DEPTH],
   output logic [PC_W-1:0]  end_o   [DEPTH],
   output logic [CNT_W-1:0] cnt_o   [DEPTH]
);

   logic [SPW-1:0] sp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sp_q <= '0;
      else if (push_i) sp_q <= sp_q + SPW'(1);
      else             sp_q <= sp_q - pop_n_i;
   end

   assign sp_o = sp_q;

   for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
      logic [PC_W-1:0]  s_q;
      logic [PC_W-1:0]  e_q;
      logic [CNT_W-1:0] c_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            s_q <= '0;
            e_q <= '0;
            c_q <= '0;
         end else if (push_i && sp_q == SPW'(l)) begin
            s_q <= push_start_i;
            e_q <= push_end_i;
            c_q <= push_cnt_i;
         end else if (!push_i && dec_i && dec_idx_i == IDXW'(l)) begin
            c_q <= c_q - CNT_W'(1);
         end
      end

      assign start_o[l] = s_q;
      assign end_o[l]   = e_q;
      assign cnt_o[l]   = c_q;
   end

   AST_SP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sp_q <= SPW'(DEPTH)); // R4
   AST_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i |-> sp_q < SPW'(DEPTH)); // R4
   AST_POP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_n_i <= sp_q); // R12

endmodule

// File: rtl/hwloop_seek.sv
module hwloop_seek #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned PC_W  = 10,
   parameter int unsigned CNT_W = 32,
   parameter int unsigned SPW   = $clog2(DEPTH + 1),
   parameter int unsigned IDXW  = $clog2(DEPTH)
) (
   input  logic [PC_W-1:0]  pc_i,
   input  logic [SPW-1:0]   sp_i,
   input  logic [PC_W-1:0]  start_i [DEPTH],
   input  logic [PC_W-1:0]  end_i   [DEPTH],
   input  logic [CNT_W-1:0] cnt_i   [DEPTH],
   output logic             hit_o,
   output logic [SPW-1:0]   pop_n_o,
   output logic             dec_o,
   output logic [IDXW-1:0]  dec_idx_o,
   output logic [PC_W-1:0]  tgt_o
);

   logic [DEPTH-1:0] match;
   logic [DEPTH-1:0] last;

   for (genvar l = 0; l < DEPTH; l++) begin : g_cmp
      assign match[l] = (SPW'(l) < sp_i) && (end_i[l] == pc_i);
      assign last[l]  = (cnt_i[l] == CNT_W'(1));
   end

   // Walk down from the top: retire finished entries sharing this end
   // address, and stop at the first one that still has iterations left.
   always_comb begin
      logic done;
      done      = 1'b0;
      hit_o     = 1'b0;
      pop_n_o   = '0;
      dec_o     = 1'b0;
      dec_idx_o = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (!done && SPW'(k) < sp_i) begin
            if (match[k]) begin
               hit_o = 1'b1;
               if (last[k]) begin
                  pop_n_o = pop_n_o + SPW'(1);
               end else begin
                  dec_o     = 1'b1;
                  dec_idx_o = IDXW'(k);
                  done      = 1'b1;
               end
            end else begin
               done = 1'b1;
            end
         end
      end
   end

   assign tgt_o = start_i[dec_idx_o];

endmodule

// File: rtl/hwloop_guard.sv
module hwloop_guard
   import hwloop_pkg::*;
#(
   parameter int unsigned IMEM_WORDS = 1024,
   parameter int unsigned DEPTH      = 8,
   parameter int unsigned PC_W       = 10,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned SPW        = $clog2(DEPTH + 1)
) (
   input  logic             vld_i,
   input  logic             loop_req_i,
   input  logic             is_xfer_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic [LEN_W-1:0] body_len_i,
   input  logic [SPW-1:0]   sp_i,
   input  logic             at_end_i,
   output logic [PC_W-1:0]  end_o,
   output loop_err_t        err_o
);

   localparam logic [PC_W:0] TOP_WORD = (PC_W + 1)'(IMEM_WORDS - 1);

   logic [PC_W:0] end_ext;
   logic          start;

   assign end_ext = {1'b0, pc_i} + (PC_W + 1)'(body_len_i) + (PC_W + 1)'(1);
   assign end_o   = end_ext[PC_W-1:0];
   assign start   = vld_i && loop_req_i;

   always_comb begin
      err_o              = '0;
      err_o.zero_cnt     = start && (cnt_i == '0);
      err_o.bad_end      = start && (end_ext > TOP_WORD);
      err_o.stack_full   = start && (sp_i == SPW'(DEPTH));
      err_o.start_at_end = start && at_end_i;
      err_o.xfer_at_end  = vld_i && is_xfer_i && at_end_i;
   end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
   import hwloop_pkg::*;
#(
   parameter int unsigned IMEM_WORDS  = 1024,
   parameter int unsigned STACK_DEPTH = 8,
   parameter int unsigned CNT_W       = DEF_CNT_W,
   parameter int unsigned IMM_W       = 10,
   parameter int unsigned LEN_W       = 8,
   parameter int unsigned PC_W        = $clog2(IMEM_WORDS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             insn_vld_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic             is_xfer_i,
   input  logic             loop_req_i,
   input  logic             cnt_imm_sel_i,
   input  logic [IMM_W-1:0] cnt_imm_i,
   input  logic [CNT_W-1:0] cnt_reg_i,
   input  logic [LEN_W-1:0] body_len_i,
   output logic             redir_vld_o,
   output logic [PC_W-1:0]  redir_pc_o,
   output logic             err_zero_cnt_o,
   output logic             err_bad_end_o,
   output logic             err_stack_full_o,
   output logic             err_start_at_end_o,
   output logic             err_xfer_at_end_o
);

   localparam int unsigned SPW  = $clog2(STACK_DEPTH + 1);
   localparam int unsigned IDXW = $clog2(STACK_DEPTH);

   if (STACK_DEPTH < 2) begin : g_bad_depth
      $error("STACK_DEPTH must be at least 2");
   end
   if (LEN_W > PC_W) begin : g_bad_len
      $error("LEN_W must not exceed PC_W");
   end
   if (IMM_W > CNT_W) begin : g_bad_imm
      $error("IMM_W must not exceed CNT_W");
   end
   if (IMEM_WORDS > (1 << PC_W)) begin : g_bad_pcw
      $error("PC_W too narrow for IMEM_WORDS");
   end

   logic [CNT_W-1:0] cnt_sel;
   logic [SPW-1:0]   sp;
   logic [PC_W-1:0]  ent_start [STACK_DEPTH];
   logic [PC_W-1:0]  ent_end   [STACK_DEPTH];
   logic [CNT_W-1:0] ent_cnt   [STACK_DEPTH];
   logic             hit;
   logic [SPW-1:0]   pop_n;
   logic             dec;
   logic [IDXW-1:0]  dec_idx;
   logic [PC_W-1:0]  tgt;
   logic [PC_W-1:0]  new_end;
   loop_err_t        errs;
   logic             any_err;
   logic             push;
   logic             retire;

   assign cnt_sel = cnt_imm_sel_i ? CNT_W'(cnt_imm_i) : cnt_reg_i;

   hwloop_seek #(
      .DEPTH(STACK_DEPTH), .PC_W(PC_W), .CNT_W(CNT_W), .SPW(SPW), .IDXW(IDXW)
   ) u_seek (
      .pc_i     (pc_i),
      .sp_i     (sp),
      .start_i  (ent_start),
      .end_i    (ent_end),
      .cnt_i    (ent_cnt),
      .hit_o    (hit),
      .pop_n_o  (pop_n),
      .dec_o    (dec),
      .dec_idx_o(dec_idx),
      .tgt_o    (tgt)
   );

   hwloop_guard #(
      .IMEM_WORDS(IMEM_WORDS), .DEPTH(STACK_DEPTH), .PC_W(PC_W),
      .CNT_W(CNT_W), .LEN_W(LEN_W), .SPW(SPW)
   ) u_guard (
      .vld_i     (insn_vld_i),
      .loop_req_i(loop_req_i),
      .is_xfer_i (is_xfer_i),
      .cnt_i     (cnt_sel),
      .pc_i      (pc_i),
      .body_len_i(body_len_i),
      .sp_i      (sp),
      .at_end_i  (hit),
      .end_o     (new_end),
      .err_o     (errs)
   );

   assign any_err = |errs;
   assign push    = insn_vld_i && loop_req_i && !any_err;
   assign retire  = insn_vld_i && !loop_req_i && hit && !any_err;

   hwloop_stack #(
      .DEPTH(STACK_DEPTH), .PC_W(PC_W), .CNT_W(CNT_W), .SPW(SPW), .IDXW(IDXW)
   ) u_stack (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push),
      .push_start_i(pc_i + PC_W'(1)),
      .push_end_i  (new_end),
      .push_cnt_i  (cnt_sel),
      .pop_n_i     (retire ? pop_n : '0),
      .dec_i       (retire && dec),
      .dec_idx_i   (dec_idx),
      .sp_o        (sp),
      .start_o     (ent_start),
      .end_o       (ent_end),
      .cnt_o       (ent_cnt)
   );

   assign redir_vld_o        = retire && dec;
   assign redir_pc_o         = tgt;
   assign err_zero_cnt_o     = errs.zero_cnt;
   assign err_bad_end_o      = errs.bad_end;
   assign err_stack_full_o   = errs.stack_full;
   assign err_start_at_end_o = errs.start_at_end;
   assign err_xfer_at_end_o  = errs.xfer_at_end;

   AST_ERR_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_err |=> sp == $past(sp)); // R7
   AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push |=> sp == $past(sp) + SPW'(1)); // R1
   AST_DONE_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (retire && !redir_vld_o) |=> sp < $past(sp)); // R9
   AST_XFER_NO_REDIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (insn_vld_i && is_xfer_i && hit) |-> !redir_vld_o); // R6
   AST_REDIR_IN_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redir_vld_o |-> ({1'b0, redir_pc_o} < (PC_W + 1)'(IMEM_WORDS))); // R10

endmodule

// File: tb/hwloop_ctrl_bench.sv
module hwloop_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld = 1'b0;
   logic [9:0]  pc = '0;
   logic        xfer = 1'b0;
   logic        req = 1'b0;
   logic        isel = 1'b0;
   logic [9:0]  imm = '0;
   logic [31:0] rcnt = '0;
   logic [7:0]  blen = '0;
   logic        rv;
   logic [9:0]  rpc;
   logic        e_zero, e_end, e_full, e_sae, e_xae;

   int n_chk = 0;
   int n_bad = 0;

   // Captured outputs of the last issued instruction.
   logic        c_rv;
   logic [9:0]  c_rpc;
   logic [4:0]  c_err; // {zero, bad_end, full, start_at_end, xfer_at_end}

   always #2.5 clk = ~clk;

   hwloop_ctrl u_hwloop_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .insn_vld_i(vld), .pc_i(pc),
      .is_xfer_i(xfer), .loop_req_i(req), .cnt_imm_sel_i(isel),
      .cnt_imm_i(imm), .cnt_reg_i(rcnt), .body_len_i(blen),
      .redir_vld_o(rv), .redir_pc_o(rpc),
      .err_zero_cnt_o(e_zero), .err_bad_end_o(e_end),
      .err_stack_full_o(e_full), .err_start_at_end_o(e_sae),
      .err_xfer_at_end_o(e_xae)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic issue(input int p, input bit r, input bit s, input int im,
                        input logic [31:0] rc, input int bl, input bit x);
      @(negedge clk);
      vld = 1'b1; pc = 10'(p); req = r; isel = s; imm = 10'(im);
      rcnt = rc; blen = 8'(bl); xfer = x;
      #1;
      c_rv  = rv;
      c_rpc = rpc;
      c_err = {e_zero, e_end, e_full, e_sae, e_xae};
   endtask

   task automatic run(input string tag, input int p, input bit exp_rv, input int exp_pc);
      issue(p, 0, 0, 0, 0, 0, 0);
      chk({tag, " redirect"}, 32'(c_rv), 32'(exp_rv));
      if (exp_rv) chk({tag, " target"}, 32'(c_rpc), 32'(exp_pc));
      chk({tag, " errors"}, 32'(c_err), 0);
   endtask

   task automatic start(input string tag, input int p, input logic [31:0] cnt,
                        input int bl, input logic [4:0] exp_err);
      issue(p, 1, 0, 0, cnt, bl, 0);
      chk({tag, " errors"}, 32'(c_err), 32'(exp_err));
      chk({tag, " no redirect"}, 32'(c_rv), 0);
   endtask

   task automatic t_reset;
      run("R10 empty stack", 5, 0, 0);
      run("R10 empty stack again", 1023, 0, 0);
   endtask

   task automatic t_imm_count;
      // R1: immediate count 3 selected, register count ignored.
      issue(10, 1, 1, 3, 32'd9, 1, 0);
      chk("R1 imm start errors", 32'(c_err), 0);
      for (int i = 0; i < 2; i++) begin
         run("R10 body", 11, 0, 0);
         run("R10 loopback", 12, 1, 11);
      end
      run("R1 body last", 11, 0, 0);
      run("R1 third pass falls through", 12, 0, 0);
      run("R1 popped", 12, 0, 0);
   endtask

   task automatic t_reg_count;
      // R1: register count 2, immediate 7 ignored.
      issue(20, 1, 0, 7, 32'd2, 0, 0);
      chk("R1 reg start errors", 32'(c_err), 0);
      run("R1 reg loopback", 21, 1, 21);
      run("R1 reg done", 21, 0, 0);
      run("R1 reg popped", 21, 0, 0);
   endtask

   task automatic t_shortest;
      start("R9 start", 30, 1, 0, 0);
      run("R9 single pass", 31, 0, 0);
      run("R9 retired", 31, 0, 0);
   endtask

   task automatic t_zero;
      start("R2 zero count", 40, 0, 2, 5'b10000);
      run("R2 nothing pushed", 43, 0, 0);
   endtask

   task automatic t_range;
      start("R3 end past top", 1020, 1, 5, 5'b01000);
      start("R3 end at top", 1020, 1, 2, 0);
      run("R3 top end retires", 1023, 0, 0);
      run("R3 empty after", 1023, 0, 0);
   endtask

   task automatic fill_drain(input string tag);
      for (int k = 0; k < 8; k++) start({tag, " fill"}, 100 + k, 1, 99 - 2 * k, 0);
      start({tag, " ninth"}, 108, 1, 10, 5'b00100);
      for (int k = 7; k >= 0; k--) run({tag, " drain"}, 200 - k, 0, 0);
   endtask

   task automatic t_full;
      fill_drain("R4");
      fill_drain("R12 refill");
   endtask

   task automatic t_start_at_end;
      start("R5 outer", 50, 2, 9, 0);
      start("R5 start on end", 60, 3, 1, 5'b00010);
      run("R5 unchanged loopback", 60, 1, 51);
      run("R5 done", 60, 0, 0);
   endtask

   task automatic t_xfer;
      start("R6 loop", 70, 2, 4, 0);
      issue(75, 0, 0, 0, 0, 0, 1);
      chk("R6 jump at end error", 32'(c_err), 32'(5'b00001));
      chk("R6 no redirect", 32'(c_rv), 0);
      run("R13 jump into end", 75, 1, 71);
      issue(73, 0, 0, 0, 0, 0, 1);
      chk("R13 jump mid body", 32'(c_err), 0);
      run("R6 done", 75, 0, 0);
   endtask

   task automatic t_bad_nest;
      start("R8 outer", 80, 2, 9, 0);
      start("R8 inner", 82, 2, 10, 0);
      run("R8 outer end inside inner", 90, 0, 0);
      run("R8 inner loopback", 93, 1, 83);
      run("R8 outer end again", 90, 0, 0);
      run("R8 inner done", 93, 0, 0);
      run("R8 outer loopback", 90, 1, 81);
      run("R8 outer done", 90, 0, 0);
   endtask

   task automatic t_shared_end;
      start("R11 outer", 110, 2, 9, 0);
      start("R11 inner same end", 112, 2, 7, 0);
      run("R11 inner loopback", 120, 1, 113);
      run("R11 inner done outer loops", 120, 1, 111);
      run("R11 outer done", 120, 0, 0);
      run("R11 empty", 120, 0, 0);
   endtask

   task automatic t_multi_err;
      start("R7 zero and range", 1020, 0, 5, 5'b11000);
      start("R7 loop", 130, 2, 1, 0);
      start("R7 zero at end", 132, 0, 0, 5'b10010);
      run("R7 state kept", 132, 1, 131);
      run("R7 done", 132, 0, 0);
   endtask

   task automatic t_max_count;
      start("R1 all ones", 300, 32'hFFFF_FFFF, 0, 0);
      run("R1 all ones loopback", 301, 1, 301);
      run("R1 all ones loopback 2", 301, 1, 301);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_imm_count();
      t_reg_count();
      t_shortest();
      t_zero();
      t_range();
      t_full();
      t_start_at_end();
      t_xfer();
      t_bad_nest();
      t_shared_end();
      t_multi_err();
      t_max_count();
      @(negedge clk);
      vld = 1'b0;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule